// File: doc/BRIEF.md
# Status Flag Update Unit

This block holds the carry, auxiliary-carry and overflow bits of a processor status word. Each time the pipeline retires an instruction it raises a strobe and presents a 3-bit instruction class with the ALU side results. The side results are the carry-out, the nibble carry, the signed overflow and a single-bit boolean result. The class sets the rule for each flag. A flag can be held, forced to a constant, inverted, or loaded from one of the ALU results.

A separate software write port loads all three flags at once. When both ports are active in the same clock, the software write wins. The ALU itself and the parity flag are outside this block.

Top module: `pswflag_unit`

## Requirements
- R1: An active-low reset clears carry, auxiliary carry and overflow to 0.
- R2: When neither flagWe nor swWe is high at a clock edge, all three flags keep their value.
- R3: Class 0 (increment/decrement) leaves all three flags unchanged even when flagWe is high.
- R4: Class 1 (add, add with carry, subtract with borrow) loads carry from aluCarry, auxiliary carry from aluNibbleCarry and overflow from aluOverflow.
- R5: Class 2 (multiply/divide) clears carry, loads overflow from aluOverflow, and leaves auxiliary carry unchanged.
- R6: Class 3 forces carry to 1 and class 4 forces carry to 0. Auxiliary carry and overflow are unchanged.
- R7: Class 5 inverts carry. The other two flags are unchanged.
- R8: Class 6 (boolean bit operations into carry) loads carry from bitResult and ignores aluCarry. The other two flags are unchanged.
- R9: Class 7 (rotate through carry, decimal adjust, compare-and-jump) loads carry from aluCarry. For a compare, aluCarry is the borrow that is high when the first operand is below the second as unsigned numbers. The other two flags are unchanged.
- R10: When swWe is high, the flags load swCarry, swAux and swOverflow, whatever flagWe and instClass are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| instClass | input | 3 | Instruction class code (0..7, see R3-R9) |
| aluCarry | input | 1 | ALU carry-out / borrow |
| aluNibbleCarry | input | 1 | Carry out of bit 3 |
| aluOverflow | input | 1 | Signed overflow from the ALU |
| bitResult | input | 1 | Result of a boolean bit operation |
| flagWe | input | 1 | Instruction-driven update strobe |
| swWe | input | 1 | Software write strobe |
| swCarry | input | 1 | Software value for carry |
| swAux | input | 1 | Software value for auxiliary carry |
| swOverflow | input | 1 | Software value for overflow |
| carryFlag | output | 1 | Registered carry |
| auxFlag | output | 1 | Registered auxiliary carry |
| overflowFlag | output | 1 | Registered overflow |

## Verification
The hard case is telling "unchanged" apart from "loaded with the same value". To do that, the bench first puts the auxiliary-carry and overflow bits into values the ALU inputs of the next operation would overturn. It then issues the carry-only classes with those opposing ALU inputs. The software-priority case is reached by raising both strobes in the same cycle, with an instruction class and ALU inputs whose result differs from the software data.

// File: rtl/pswflag_pkg.sv
package pswflag_pkg;
  parameter int CLASS_W = 3;

  typedef enum logic [CLASS_W-1:0] {
    CLS_KEEP   = 3'd0,
    CLS_ARITH  = 3'd1,
    CLS_MULDIV = 3'd2,
    CLS_SETC   = 3'd3,
    CLS_CLRC   = 3'd4,
    CLS_CPLC   = 3'd5,
    CLS_BITC   = 3'd6,
    CLS_ALUC   = 3'd7
  } instClass_e;

  typedef enum logic [2:0] {
    CSRC_ZERO,
    CSRC_ONE,
    CSRC_ALU,
    CSRC_BIT,
    CSRC_INV
  } carrySrc_e;

  typedef struct packed {
    logic      swLoad;
    logic      loadC;
    logic      loadAc;
    logic      loadOv;
    carrySrc_e cSrc;
  } flagStrobe_t;
endpackage

// File: rtl/pswflag_ctrl.sv
module pswflag_ctrl
  import pswflag_pkg::*;
(
  input  logic [CLASS_W-1:0] instClass,
  input  logic               flagWe,
  input  logic               swWe,
  output flagStrobe_t        strobe
);
  instClass_e cls;
  assign cls = instClass_e'(instClass);

  always_comb begin
    strobe        = '0;
    strobe.cSrc   = CSRC_ALU;
    strobe.swLoad = swWe;
    if (flagWe && !swWe) begin
      unique case (cls)
        CLS_KEEP:   ;
        CLS_ARITH:  begin
          strobe.loadC  = 1'b1;
          strobe.loadAc = 1'b1;
          strobe.loadOv = 1'b1;
          strobe.cSrc   = CSRC_ALU;
        end
        CLS_MULDIV: begin
          strobe.loadC  = 1'b1;
          strobe.loadOv = 1'b1;
          strobe.cSrc   = CSRC_ZERO;
        end
        CLS_SETC:   begin strobe.loadC = 1'b1; strobe.cSrc = CSRC_ONE;  end
        CLS_CLRC:   begin strobe.loadC = 1'b1; strobe.cSrc = CSRC_ZERO; end
        CLS_CPLC:   begin strobe.loadC = 1'b1; strobe.cSrc = CSRC_INV;  end
        CLS_BITC:   begin strobe.loadC = 1'b1; strobe.cSrc = CSRC_BIT;  end
        CLS_ALUC:   begin strobe.loadC = 1'b1; strobe.cSrc = CSRC_ALU;  end
        default:    ;
      endcase
    end
  end
endmodule

// File: rtl/pswflag_dp.sv
module pswflag_dp
  import pswflag_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  flagStrobe_t strobe,
  input  logic        aluCarry,
  input  logic        aluNibbleCarry,
  input  logic        aluOverflow,
  input  logic        bitResult,
  input  logic        swCarry,
  input  logic        swAux,
  input  logic        swOverflow,
  output logic        carryQ,
  output logic        auxQ,
  output logic        ovfQ
);
  logic nextCarry;

  always_comb begin
    unique case (strobe.cSrc)
      CSRC_ZERO: nextCarry = 1'b0;
      CSRC_ONE:  nextCarry = 1'b1;
      CSRC_ALU:  nextCarry = aluCarry;
      CSRC_BIT:  nextCarry = bitResult;
      CSRC_INV:  nextCarry = ~carryQ;
      default:   nextCarry = carryQ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      carryQ <= 1'b0;
      auxQ   <= 1'b0;
      ovfQ   <= 1'b0;
    end else if (strobe.swLoad) begin
      carryQ <= swCarry;
      auxQ   <= swAux;
      ovfQ   <= swOverflow;
    end else begin
      if (strobe.loadC)  carryQ <= nextCarry;
      if (strobe.loadAc) auxQ   <= aluNibbleCarry;
      if (strobe.loadOv) ovfQ   <= aluOverflow;
    end
  end
endmodule

// File: rtl/pswflag_unit.sv
module pswflag_unit
  import pswflag_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [CLASS_W-1:0] instClass,
  input  logic               aluCarry,
  input  logic               aluNibbleCarry,
  input  logic               aluOverflow,
  input  logic               bitResult,
  input  logic               flagWe,
  input  logic               swWe,
  input  logic               swCarry,
  input  logic               swAux,
  input  logic               swOverflow,
  output logic               carryFlag,
  output logic               auxFlag,
  output logic               overflowFlag
);
  flagStrobe_t strobe;

  pswflag_ctrl i_ctrl (
    .instClass (instClass),
    .flagWe    (flagWe),
    .swWe      (swWe),
    .strobe    (strobe)
  );

  pswflag_dp i_dp (
    .clk            (clk),
    .rstN           (rstN),
    .strobe         (strobe),
    .aluCarry       (aluCarry),
    .aluNibbleCarry (aluNibbleCarry),
    .aluOverflow    (aluOverflow),
    .bitResult      (bitResult),
    .swCarry        (swCarry),
    .swAux          (swAux),
    .swOverflow     (swOverflow),
    .carryQ         (carryFlag),
    .auxQ           (auxFlag),
    .ovfQ           (overflowFlag)
  );
endmodule

// File: rtl/pswflag_chk.sv
module pswflag_chk
  import pswflag_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic [CLASS_W-1:0] instClass,
  input logic               aluCarry,
  input logic               aluNibbleCarry,
  input logic               aluOverflow,
  input logic               bitResult,
  input logic               flagWe,
  input logic               swWe,
  input logic               swCarry,
  input logic               swAux,
  input logic               swOverflow,
  input logic               carryFlag,
  input logic               auxFlag,
  input logic               overflowFlag
);
  logic instUpd;
  assign instUpd = flagWe && !swWe;

  // R2
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!flagWe && !swWe) |=> ($stable(carryFlag) && $stable(auxFlag) && $stable(overflowFlag)));

  // R3
  keep_class_chk: assert property (@(posedge clk) disable iff (!rstN)
    (instUpd && instClass == 3'd0) |=> ($stable(carryFlag) && $stable(auxFlag) && $stable(overflowFlag)));

  // R4
  arith_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (instUpd && instClass == 3'd1) |=>
      (carryFlag == $past(aluCarry) && auxFlag == $past(aluNibbleCarry) && overflowFlag == $past(aluOverflow)));

  // R5
  muldiv_chk: assert property (@(posedge clk) disable iff (!rstN)
    (instUpd && instClass == 3'd2) |=>
      (!carryFlag && $stable(auxFlag) && overflowFlag == $past(aluOverflow)));

  // R6
  setc_chk: assert property (@(posedge clk) disable iff (!rstN)
    (instUpd && instClass == 3'd3) |=> (carryFlag && $stable(auxFlag) && $stable(overflowFlag)));

  // R6
  clrc_chk: assert property (@(posedge clk) disable iff (!rstN)
    (instUpd && instClass == 3'd4) |=> (!carryFlag && $stable(auxFlag) && $stable(overflowFlag)));

  // R7
  cplc_chk: assert property (@(posedge clk) disable iff (!rstN)
    (instUpd && instClass == 3'd5) |=> (carryFlag != $past(carryFlag)));

  // R8
  bitc_chk: assert property (@(posedge clk) disable iff (!rstN)
    (instUpd && instClass == 3'd6) |=> (carryFlag == $past(bitResult) && $stable(auxFlag)));

  // R9
  aluc_chk: assert property (@(posedge clk) disable iff (!rstN)
    (instUpd && instClass == 3'd7) |=> (carryFlag == $past(aluCarry) && $stable(overflowFlag)));

  // R10
  sw_priority_chk: assert property (@(posedge clk) disable iff (!rstN)
    swWe |=> (carryFlag == $past(swCarry) && auxFlag == $past(swAux) && overflowFlag == $past(swOverflow)));
endmodule

bind pswflag_unit pswflag_chk i_chk (
  .clk            (clk),
  .rstN           (rstN),
  .instClass      (instClass),
  .aluCarry       (aluCarry),
  .aluNibbleCarry (aluNibbleCarry),
  .aluOverflow    (aluOverflow),
  .bitResult      (bitResult),
  .flagWe         (flagWe),
  .swWe           (swWe),
  .swCarry        (swCarry),
  .swAux          (swAux),
  .swOverflow     (swOverflow),
  .carryFlag      (carryFlag),
  .auxFlag        (auxFlag),
  .overflowFlag   (overflowFlag)
);

// File: tb/test_pswflag_unit.sv
`timescale 1ns/1ps
module test_pswflag_unit;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [2:0] instClass = '0;
  logic aluCarry = 0, aluNibbleCarry = 0, aluOverflow = 0, bitResult = 0;
  logic flagWe = 0, swWe = 0, swCarry = 0, swAux = 0, swOverflow = 0;
  logic carryFlag, auxFlag, overflowFlag;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  pswflag_unit i_pswflag_unit (
    .clk(clk), .rstN(rstN), .instClass(instClass),
    .aluCarry(aluCarry), .aluNibbleCarry(aluNibbleCarry), .aluOverflow(aluOverflow),
    .bitResult(bitResult), .flagWe(flagWe), .swWe(swWe),
    .swCarry(swCarry), .swAux(swAux), .swOverflow(swOverflow),
    .carryFlag(carryFlag), .auxFlag(auxFlag), .overflowFlag(overflowFlag)
  );

  task automatic checkFlags(string req, logic eC, logic eA, logic eO);
    nChecks++;
    if (carryFlag !== eC || auxFlag !== eA || overflowFlag !== eO) begin
      nFails++;
      $display("FAIL %s: C/AC/OV actual %b%b%b expected %b%b%b",
               req, carryFlag, auxFlag, overflowFlag, eC, eA, eO);
    end
  endtask

  // Drive at a falling edge, let one rising edge pass, then drop strobes.
  task automatic issue(logic [2:0] cls, logic c, logic ac, logic ov, logic b,
                       logic we, logic sw, logic sc, logic sa, logic so);
    @(negedge clk);
    instClass = cls; aluCarry = c; aluNibbleCarry = ac; aluOverflow = ov;
    bitResult = b; flagWe = we; swWe = sw; swCarry = sc; swAux = sa; swOverflow = so;
    @(negedge clk);
    flagWe = 0; swWe = 0;
  endtask

  task automatic testReset();
    checkFlags("R1", 0, 0, 0);
  endtask

  task automatic testHold();
    issue(3'd1, 1, 1, 1, 1, 0, 0, 0, 0, 0);
    checkFlags("R2", 0, 0, 0);
  endtask

  task automatic testArith();
    issue(3'd1, 1, 1, 1, 0, 1, 0, 0, 0, 0);
    checkFlags("R4", 1, 1, 1);
    issue(3'd1, 0, 1, 0, 1, 1, 0, 0, 0, 0);
    checkFlags("R4", 0, 1, 0);
  endtask

  task automatic testKeep();
    issue(3'd0, 1, 0, 1, 1, 1, 0, 0, 0, 0);
    checkFlags("R3", 0, 1, 0);
  endtask

  task automatic testMulDiv();
    issue(3'd3, 0, 0, 0, 0, 1, 0, 0, 0, 0);
    checkFlags("R6", 1, 1, 0);
    issue(3'd2, 1, 0, 1, 1, 1, 0, 0, 0, 0);
    checkFlags("R5", 0, 1, 1);
  endtask

  task automatic testSetClr();
    issue(3'd3, 0, 0, 0, 0, 1, 0, 0, 0, 0);
    checkFlags("R6", 1, 1, 1);
    issue(3'd4, 1, 0, 0, 1, 1, 0, 0, 0, 0);
    checkFlags("R6", 0, 1, 1);
  endtask

  task automatic testComplement();
    issue(3'd5, 0, 0, 0, 0, 1, 0, 0, 0, 0);
    checkFlags("R7", 1, 1, 1);
    issue(3'd5, 1, 0, 0, 1, 1, 0, 0, 0, 0);
    checkFlags("R7", 0, 1, 1);
  endtask

  task automatic testBit();
    issue(3'd6, 0, 0, 0, 1, 1, 0, 0, 0, 0);
    checkFlags("R8", 1, 1, 1);
    issue(3'd6, 1, 0, 0, 0, 1, 0, 0, 0, 0);
    checkFlags("R8", 0, 1, 1);
  endtask

  task automatic testAluCarry();
    // compare 0x12 with 0x80: first below second, so borrow is 1
    issue(3'd7, 1, 0, 0, 0, 1, 0, 0, 0, 0);
    checkFlags("R9", 1, 1, 1);
    issue(3'd7, 0, 0, 0, 1, 1, 0, 0, 0, 0);
    checkFlags("R9", 0, 1, 1);
  endtask

  task automatic testSwPriority();
    issue(3'd3, 1, 1, 1, 1, 1, 1, 0, 0, 0);
    checkFlags("R10", 0, 0, 0);
    issue(3'd1, 0, 1, 0, 0, 1, 1, 1, 0, 1);
    checkFlags("R10", 1, 0, 1);
    issue(3'd0, 0, 0, 0, 0, 0, 1, 0, 1, 0);
    checkFlags("R10", 0, 1, 0);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testHold();
    testArith();
    testKeep();
    testMulDiv();
    testSetClr();
    testComplement();
    testBit();
    testAluCarry();
    testSwPriority();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule